// File: doc/BRIEF.md
# Tuner Synthesizer Register Interface over I2C

This block is the programming front end of a television tuner frequency synthesizer. It is an I2C slave that watches SCL and SDA, both sampled by a much faster system clock. It decodes the bytes a bus master writes into three registers: a 15-bit programmable divider word, a 7-bit control word and a 4-bit band-port word. It drives an open-drain SDA to acknowledge and to return one status byte on a read. The latched values go straight to the synthesizer datapath and the band drivers. A VHF/UHF mode line is derived from the two lowest band ports.

After the address byte, every data byte classifies itself by its most significant bit. A clear MSB starts a divider pair. A set MSB is a control byte, and the byte after it is always taken as band data. The two divider bytes take effect together. The control and band bytes each take effect at their own acknowledge, so a master can re-tune, change the reference, or sweep several frequencies inside one transaction without repeating the address.

Top module: `tuner_i2c_regs`

## Requirements
- R1: The slave address is the fixed 5-bit prefix 11000 followed by `addr_sel_i[1]`, `addr_sel_i[0]`; the eighth address bit selects read (1) or write (0). On a match the block pulls SDA low throughout the ninth clock (`sda_oe_o`=1).
- R2: With a non-matching address the block gives no acknowledge and keeps SDA released, and it ignores every further byte until the next START. Its registers stay unchanged.
- R3: A write data byte with bit 7 = 0 carries divider bits 14..8 in its bits 6..0. The next byte carries divider bits 7..0. `div_o` is unchanged after the first byte and takes the full 15-bit value at the acknowledge of the second.
- R4: A write data byte with bit 7 = 1 is a control byte. Its bits 6..0 map to `cp_o`, `test_o[2:0]`, `ref_sel_o[1]`, `ref_sel_o[0]`, `amp_off_o`, in that order from bit 6 down. It is latched at its acknowledge. The next byte is band data: its bits 3..0 go to `band_o[3:0]` and its bits 7..4 are ignored.
- R5: Once a divider pair or a control/band pair is complete, the next byte is classified again by bit 7. Any number of pairs in either order may follow one address before STOP.
- R6: A STOP or a repeated START discards a divider first byte that is still waiting for its partner and leaves all latched registers as they were. After a STOP, SDA is released.
- R7: In a read, after the address acknowledge the block shifts out one status byte MSB first: bit 7 is the power-on flag, bit 6 is `lock_i`, and bits 5..0 are 1. It repeats a fresh status byte while the master acknowledges, and releases the bus after a master not-acknowledge.
- R8: The power-on flag is 1 after reset. It is cleared once a status byte has been shifted out, so a following byte or read shows 0. A pulse on `por_evt_i` sets it again.
- R9: After reset: `div_o`=0, `cp_o`=0, `test_o`=000, `ref_sel_o`=11, `amp_off_o`=1, `band_o`=0000, `sda_oe_o`=0.
- R10: `vhf_o` is 1 when `band_o[0]` or `band_o[1]` is 1, and 0 (UHF) when both are 0.
- R11: Every write data byte that follows a matching address is acknowledged with SDA low in its ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_sel_i | input | 2 | Hardware address select, low two address bits |
| por_evt_i | input | 1 | Pulse that sets the power-on flag |
| lock_i | input | 1 | Synthesizer lock indication, reported in status |
| div_o | output | 15 | Active programmable divider word |
| cp_o | output | 1 | Charge-pump current select (1 = high) |
| test_o | output | 3 | Test-mode field |
| ref_sel_o | output | 2 | Reference divider select |
| amp_off_o | output | 1 | 1 disables the tuning amplifier |
| band_o | output | 4 | Band port drive bits |
| vhf_o | output | 1 | 1 = VHF mode, 0 = UHF mode |

## Verification
The bench builds the block with its default two-stage input synchronizer and the 11000 address prefix. It toggles the bus at 8 system clocks per quarter bit, so the three-cycle detection latency sits well inside each SCL phase. With these values a full multi-pair write, a repeated START in the middle of a divider pair, and a two-byte read whose second byte already shows the cleared power-on flag all fit in a few thousand cycles. Two values of the address select are driven, which makes both the match and the mismatch path reachable.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;

  localparam int BYTE_W   = 8;
  localparam int DEV_ID_W = 5;
  localparam int SEL_W    = 2;
  localparam int DIV_W    = 15;
  localparam int HI_W     = DIV_W - BYTE_W;
  localparam int CTRL_W   = 7;
  localparam int BAND_W   = 4;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } bus_state_e;

  typedef enum logic [1:0] {
    EXP_ANY,
    EXP_DIV2,
    EXP_BAND
  } expect_e;

  typedef struct packed {
    logic       cp;
    logic [2:0] test;
    logic       rsa;
    logic       rsb;
    logic       amp_off;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{cp: 1'b0, test: 3'b000, rsa: 1'b1, rsb: 1'b1, amp_off: 1'b1};

endpackage

// File: rtl/tuner_line_sync.sv
module tuner_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sh_q, sda_sh_q;
  logic              scl_d_q, sda_d_q;
  logic              scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh_q <= '1;
      sda_sh_q <= '1;
      scl_d_q  <= 1'b1;
      sda_d_q  <= 1'b1;
    end else begin
      scl_sh_q <= {scl_sh_q[STAGES-2:0], scl_i};
      sda_sh_q <= {sda_sh_q[STAGES-2:0], sda_i};
      scl_d_q  <= scl_s;
      sda_d_q  <= sda_s;
    end
  end

  assign scl_s     = scl_sh_q[STAGES-1];
  assign sda_s     = sda_sh_q[STAGES-1];
  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_d_q;
  assign scl_fall  = ~scl_s & scl_d_q;
  assign start_det = scl_s & scl_d_q & sda_d_q & ~sda_s;
  assign stop_det  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/tuner_i2c_engine.sv
module tuner_i2c_engine
  import tuner_i2c_pkg::*;
#(
  parameter logic [DEV_ID_W-1:0] DEV_ID = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [SEL_W-1:0]  addr_sel,
  input  logic [BYTE_W-1:0] status_i,
  output logic              sda_oe,
  output logic              wr_vld,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              status_sent,
  output logic              xfer_abort
);

  bus_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              ack_q, ack_d;
  logic              drv_q, drv_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_ID, addr_sel});

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    ack_d       = ack_q;
    drv_d       = drv_q;
    rw_d        = rw_q;
    mack_d      = mack_q;
    wr_vld      = 1'b0;
    status_sent = 1'b0;
    xfer_abort  = 1'b0;
    if (start_det) begin
      state_d    = ST_ADDR;
      cnt_d      = '0;
      ack_d      = 1'b0;
      drv_d      = 1'b0;
      xfer_abort = 1'b1;
    end else if (stop_det) begin
      state_d    = ST_IDLE;
      ack_d      = 1'b0;
      drv_d      = 1'b0;
      xfer_abort = 1'b1;
    end else begin
      case (state_q)
        ST_ADDR, ST_WRITE: begin
          if (scl_rise && !ack_q && cnt_q != CNT_W'(BYTE_W)) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end
          if (scl_fall && !ack_q && cnt_q == CNT_W'(BYTE_W)) begin
            ack_d = 1'b1;
            if (state_q == ST_WRITE) begin
              drv_d  = 1'b1;
              wr_vld = 1'b1;
            end else if (addr_hit) begin
              drv_d = 1'b1;
              rw_d  = sh_q[0];
            end else begin
              state_d = ST_SKIP;
              ack_d   = 1'b0;
            end
          end
          if (scl_fall && ack_q) begin
            ack_d = 1'b0;
            cnt_d = '0;
            drv_d = 1'b0;
            if (state_q == ST_ADDR) begin
              if (rw_q) begin
                state_d = ST_READ;
                sh_d    = status_i;
                drv_d   = ~status_i[BYTE_W-1];
              end else begin
                state_d = ST_WRITE;
              end
            end
          end
        end
        ST_READ: begin
          if (scl_rise) begin
            if (ack_q) mack_d = ~sda_lvl;
            else       cnt_d  = cnt_q + 1'b1;
          end
          if (scl_fall) begin
            if (ack_q) begin
              ack_d = 1'b0;
              cnt_d = '0;
              drv_d = 1'b0;
              if (mack_q) begin
                sh_d  = status_i;
                drv_d = ~status_i[BYTE_W-1];
              end else begin
                state_d = ST_SKIP;
              end
            end else if (cnt_q == CNT_W'(BYTE_W)) begin
              ack_d       = 1'b1;
              drv_d       = 1'b0;
              status_sent = 1'b1;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b1};
              drv_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        default: begin
          drv_d = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ack_q   <= 1'b0;
      drv_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ack_q   <= ack_d;
      drv_q   <= drv_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe  = drv_q;
  assign wr_byte = sh_q;

  // R1
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R6
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R2
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_oe);

endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
  import tuner_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_vld,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              xfer_abort,
  input  logic              status_sent,
  input  logic              por_evt_i,
  input  logic              lock_i,
  output logic [DIV_W-1:0]  div_o,
  output ctrl_t             ctrl_o,
  output logic [BAND_W-1:0] band_o,
  output logic [BYTE_W-1:0] status_o
);

  expect_e           exp_q, exp_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic [DIV_W-1:0]  div_q, div_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic              por_q, por_d;

  always_comb begin
    exp_d  = exp_q;
    hi_d   = hi_q;
    div_d  = div_q;
    ctrl_d = ctrl_q;
    band_d = band_q;
    por_d  = por_q;
    if (xfer_abort) begin
      exp_d = EXP_ANY;
    end else if (wr_vld) begin
      case (exp_q)
        EXP_DIV2: begin
          div_d = {hi_q, wr_byte};
          exp_d = EXP_ANY;
        end
        EXP_BAND: begin
          band_d = wr_byte[BAND_W-1:0];
          exp_d  = EXP_ANY;
        end
        default: begin
          if (!wr_byte[BYTE_W-1]) begin
            hi_d  = wr_byte[HI_W-1:0];
            exp_d = EXP_DIV2;
          end else begin
            ctrl_d = ctrl_t'(wr_byte[CTRL_W-1:0]);
            exp_d  = EXP_BAND;
          end
        end
      endcase
    end
    if (status_sent) por_d = 1'b0;
    if (por_evt_i)   por_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q  <= EXP_ANY;
      hi_q   <= '0;
      div_q  <= '0;
      ctrl_q <= CTRL_RESET;
      band_q <= '0;
      por_q  <= 1'b1;
    end else begin
      exp_q  <= exp_d;
      hi_q   <= hi_d;
      div_q  <= div_d;
      ctrl_q <= ctrl_d;
      band_q <= band_d;
      por_q  <= por_d;
    end
  end

  assign div_o    = div_q;
  assign ctrl_o   = ctrl_q;
  assign band_o   = band_q;
  assign status_o = {por_q, lock_i, {(BYTE_W-2){1'b1}}};

  // R3
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(div_q));

  // R4
  ctrl_band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> ($stable(ctrl_q) && $stable(band_q)));

  // R8
  por_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(por_q) |-> $past(status_sent));

endmodule

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs
  import tuner_i2c_pkg::*;
#(
  parameter int                  SYNC_STAGES = 2,
  parameter logic [DEV_ID_W-1:0] DEV_ID      = 5'b11000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  addr_sel_i,
  input  logic              por_evt_i,
  input  logic              lock_i,
  output logic [DIV_W-1:0]  div_o,
  output logic              cp_o,
  output logic [2:0]        test_o,
  output logic [1:0]        ref_sel_o,
  output logic              amp_off_o,
  output logic [BAND_W-1:0] band_o,
  output logic              vhf_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_vld, status_sent, xfer_abort;
  logic [BYTE_W-1:0] wr_byte, status;
  ctrl_t             ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tuner_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  tuner_i2c_engine #(.DEV_ID(DEV_ID)) u_engine (
    .clk(clk), .rst_n(rst_int_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel_i), .status_i(status), .sda_oe(sda_oe_o),
    .wr_vld(wr_vld), .wr_byte(wr_byte), .status_sent(status_sent),
    .xfer_abort(xfer_abort)
  );

  tuner_reg_bank u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_vld(wr_vld), .wr_byte(wr_byte),
    .xfer_abort(xfer_abort), .status_sent(status_sent),
    .por_evt_i(por_evt_i), .lock_i(lock_i), .div_o(div_o),
    .ctrl_o(ctrl), .band_o(band_o), .status_o(status)
  );

  assign cp_o      = ctrl.cp;
  assign test_o    = ctrl.test;
  assign ref_sel_o = {ctrl.rsa, ctrl.rsb};
  assign amp_off_o = ctrl.amp_off;
  assign vhf_o     = band_o[0] | band_o[1];

  // R10
  vhf_mode_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (band_o[1:0] == 2'b00) |-> !vhf_o);

endmodule

// File: tb/tuner_i2c_regs_bench.sv
module tuner_i2c_regs_bench;

  localparam int Q = 8;

  logic        clk;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_oe;
  logic        sda_bus;
  logic [1:0]  addr_sel;
  logic        por_evt, lock;
  logic [14:0] div;
  logic        cp, amp_off, vhf;
  logic [2:0]  test;
  logic [1:0]  ref_sel;
  logic [3:0]  band;

  int checks = 0;
  int errors = 0;

  assign sda_bus = sda_m & ~sda_oe;

  tuner_i2c_regs u_tuner_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .por_evt_i(por_evt),
    .lock_i(lock), .div_o(div), .cp_o(cp), .test_o(test),
    .ref_sel_o(ref_sel), .amp_off_o(amp_off), .band_o(band), .vhf_o(vhf)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b1; wait_q(1);
    sda_m = 1'b1; wait_q(2);
  endtask

  task automatic bit_xfer(input logic b, output logic smp);
    sda_m = b;    wait_q(1);
    scl_m = 1'b1; wait_q(1);
    smp = sda_bus; wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    acked = ~s;
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~master_ack, s);
  endtask

  task automatic t_reset();
    check("R9 div", div, 0);
    check("R9 cp", cp, 0);
    check("R9 test", test, 0);
    check("R9 ref_sel", ref_sel, 2'b11);
    check("R9 amp_off", amp_off, 1);
    check("R9 band", band, 0);
    check("R10 uhf at reset", vhf, 0);
    check("R9 sda released", sda_oe, 0);
  endtask

  task automatic t_write_div_first();
    logic a;
    bus_start();
    wr_byte(8'hC4, a); check("R1 address ack", a, 1);
    wr_byte(8'h12, a); check("R11 div1 ack", a, 1);
    check("R3 div held after first byte", div, 0);
    wr_byte(8'h34, a); check("R11 div2 ack", a, 1);
    check("R3 div pair", div, 15'h1234);
    wr_byte(8'hC5, a); check("R11 ctrl ack", a, 1);
    check("R4 cp", cp, 1);
    check("R4 test", test, 3'b000);
    check("R4 ref_sel", ref_sel, 2'b10);
    check("R4 amp_off", amp_off, 1);
    wr_byte(8'hF2, a); check("R11 band ack", a, 1);
    check("R4 band low nibble only", band, 4'b0010);
    check("R10 vhf from band2", vhf, 1);
    bus_stop();
    check("R6 released after stop", sda_oe, 0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    wr_byte(8'hC0, a); check("R2 no ack on mismatch", a, 0);
    wr_byte(8'h05, a); check("R2 data not acked", a, 0);
    wr_byte(8'h06, a); check("R2 data not acked 2", a, 0);
    bus_stop();
    check("R2 div unchanged", div, 15'h1234);
    check("R2 band unchanged", band, 4'b0010);
  endtask

  task automatic t_ctrl_first();
    logic a;
    bus_start();
    wr_byte(8'hC4, a);
    wr_byte(8'h80, a);
    check("R5 ctrl first cp", cp, 0);
    check("R5 ctrl first ref_sel", ref_sel, 2'b00);
    check("R5 ctrl first amp_off", amp_off, 0);
    wr_byte(8'h08, a);
    check("R5 band after ctrl", band, 4'b1000);
    check("R10 uhf with band4 only", vhf, 0);
    wr_byte(8'h7F, a);
    wr_byte(8'hFF, a);
    check("R5 div after ctrl/band", div, 15'h7FFF);
    bus_stop();
  endtask

  task automatic t_sweep();
    logic a;
    bus_start();
    wr_byte(8'hC4, a);
    wr_byte(8'h01, a); wr_byte(8'h00, a);
    check("R5 sweep step 1", div, 15'h0100);
    wr_byte(8'h02, a); wr_byte(8'h03, a);
    check("R5 sweep step 2", div, 15'h0203);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    wr_byte(8'hC4, a);
    wr_byte(8'h11, a);
    bus_stop();
    check("R6 div kept after abort", div, 15'h0203);
    bus_start();
    wr_byte(8'hC4, a);
    wr_byte(8'h22, a);
    check("R6 pending discarded", div, 15'h0203);
    wr_byte(8'h44, a);
    check("R6 new pair", div, 15'h2244);
    wr_byte(8'h33, a);
    bus_start();
    wr_byte(8'hC4, a);
    wr_byte(8'h05, a);
    wr_byte(8'h66, a);
    check("R6 repeated start discards", div, 15'h0566);
    bus_stop();
    check("R6 ctrl kept", {cp, test, ref_sel, amp_off}, 7'h00);
    check("R6 band kept", band, 4'b1000);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    lock = 1'b1;
    bus_start();
    wr_byte(8'hC5, a); check("R1 read address ack", a, 1);
    rd_byte(1'b0, d);  check("R7 status with por", d, 8'hFF);
    bus_stop();
    check("R7 released after nack", sda_oe, 0);
    lock = 1'b0;
    bus_start();
    wr_byte(8'hC5, a);
    rd_byte(1'b0, d);  check("R8 por cleared", d, 8'h3F);
    bus_stop();
    lock = 1'b1;
    @(negedge clk); por_evt = 1'b1; @(negedge clk); por_evt = 1'b0;
    bus_start();
    wr_byte(8'hC5, a);
    rd_byte(1'b1, d);  check("R8 por set again", d, 8'hFF);
    rd_byte(1'b0, d);  check("R8 second byte por clear", d, 8'h7F);
    bus_stop();
  endtask

  task automatic t_other_sel();
    logic a;
    addr_sel = 2'b01;
    bus_start();
    wr_byte(8'hC4, a); check("R2 old address rejected", a, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hC2, a); check("R1 new select acked", a, 1);
    wr_byte(8'h81, a);
    wr_byte(8'h01, a);
    check("R10 vhf from band1", vhf, 1);
    check("R4 amp_off from ctrl", amp_off, 1);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    addr_sel = 2'b10; por_evt = 1'b0; lock = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_div_first();
    t_wrong_addr();
    t_ctrl_first();
    t_sweep();
    t_abort();
    t_read();
    t_other_sel();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule